// File: doc/BRIEF.md
# Memory-Mapped Serial Port with FIFO-Level Interrupts

This block is a byte-oriented asynchronous serial port that software reaches through a small register window. Bytes written to the data register are queued in a transmit FIFO and sent on the `txd` line, one frame at a time. Frames arriving on `rxd` are reassembled, then pushed into a receive FIFO, which software drains by reading the same data register. Both FIFOs are 16 bytes deep by default.

A single scaler register sets the bit time in system clocks for both directions. The frame carries an optional even parity bit. The receiver reports a parity error and a stop-bit error in the status word. A single level interrupt `irq` is the OR of two enabled conditions. The first is a transmit FIFO that has drained below a programmable threshold. The second is a receive FIFO whose fill has reached a programmable threshold.

The bus side is a plain single-cycle port. A write takes effect on the clock edge where `bus_wr` is high. During a cycle with `bus_rd` high, `bus_rdata` shows the addressed register combinationally. A read of the data register removes one byte from the receive FIFO at the end of that cycle.

Top module: `uart_mmio`

## Requirements
- R1: After reset the status word at offset 0x000 reads 0x0000_0022 (bit 5 receive-empty and bit 1 transmit-empty set, all else 0), `irq` is 0 and `txd` is high.
- R2: A write to offset 0x010 queues bits 7:0 in the transmit FIFO. Status bit 0 shows the FIFO full (16 bytes) and bit 1 shows it empty. A write while the FIFO is full is dropped.
- R3: Each queued byte is sent as one low start bit, eight data bits LSB first, an even parity bit when control bit 15 is set, and one high stop bit. Each bit lasts `scaler` clocks, where a scaler of 0 counts as 1. The line idles high.
- R4: A frame received on `rxd`, sampled at mid-bit, is pushed into the receive FIFO. A read of offset 0x010 returns the oldest byte in bits 7:0, with bits 31:8 zero, and removes it.
- R5: A read of offset 0x010 while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R6: A frame that completes while the receive FIFO holds 16 bytes is discarded. Status bit 4 shows the receive FIFO full.
- R7: With parity enabled, status bit 8 is set by a frame whose parity bit mismatches even parity. A later frame with correct parity clears it. The byte is stored in either case.
- R8: Status bit 9 is set by a frame whose stop bit is sampled low. A later frame with a high stop bit clears it.
- R9: With control bit 14 set, `irq` is high whenever the transmit FIFO holds fewer bytes than the 5-bit threshold at offset 0x008.
- R10: With control bit 13 set, `irq` is high whenever the receive FIFO holds at least as many bytes as the 5-bit threshold at offset 0x00C. With bits 14 and 13 both clear, `irq` is 0.
- R11: Control bits 15:13, the scaler at 0x004 (16 bits) and both thresholds (5 bits, upper bits of a write ignored) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is the receive overrun. It requires the receive FIFO to be full at the same moment another frame completes. It also requires a full transmit FIFO, so that writes get dropped. Both can only happen once the serial side has run for many bit times. The bench loops `txd` back into `rxd` with a long bit time and writes twenty bytes in quick succession. One byte is already in flight, sixteen fill the transmit FIFO and the rest are dropped. All seventeen transmitted frames then land in the receive FIFO, which overflows by exactly one. Parity and stop-bit faults cannot come out of the transmitter, so for those the bench breaks the loop and drives hand-built frames on `rxd`.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SCALE = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_TXTHR = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_RXTHR = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h010;

  typedef enum logic [2:0] {
    SER_IDLE,
    SER_START,
    SER_DATA,
    SER_PAR,
    SER_STOP
  } ser_state_e;

  // Clocks per bit; a zero scaler behaves as one.
  function automatic logic [31:0] bit_len(input logic [31:0] scale);
    return (scale == 32'd0) ? 32'd1 : scale;
  endfunction

  // Clocks from a start edge to the middle of the start bit.
  function automatic logic [31:0] mid_len(input logic [31:0] scale);
    logic [31:0] half;
    half = bit_len(scale) >> 1;
    return (half == 32'd0) ? 32'd1 : half;
  endfunction

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

  function automatic logic level_below(input logic [31:0] lvl, input logic [31:0] thr);
    return lvl < thr;
  endfunction

  function automatic logic level_at_least(input logic [31:0] lvl, input logic [31:0] thr);
    return lvl >= thr;
  endfunction

  function automatic logic [31:0] pack_status(
    input logic par_en, input logic txie, input logic rxie,
    input logic stop_err, input logic par_err,
    input logic rx_empty, input logic rx_full,
    input logic tx_empty, input logic tx_full);
    logic [31:0] w;
    w     = '0;
    w[15] = par_en;
    w[14] = txie;
    w[13] = rxie;
    w[9]  = stop_err;
    w[8]  = par_err;
    w[5]  = rx_empty;
    w[4]  = rx_full;
    w[1]  = tx_empty;
    w[0]  = tx_full;
    return w;
  endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];
  assign count   = cnt;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= next_ptr(wp);
      if (pop_ok)  rp <= next_ptr(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser import uart_mmio_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] scale,
  input  logic        par_en,
  input  logic        fifo_empty,
  input  logic [7:0]  fifo_dout,
  output logic        fifo_pop,
  output logic        busy,
  output logic        txd
);
  ser_state_e  st;
  logic [31:0] cnt;
  logic [7:0]  sh;
  logic [2:0]  nbit;
  logic        par_q, pbit;
  logic        bit_end;

  assign bit_end  = (cnt == bit_len(scale) - 32'd1);
  assign fifo_pop = (st == SER_IDLE) && !fifo_empty;
  assign busy     = (st != SER_IDLE);

  always_comb begin
    case (st)
      SER_START: txd = 1'b0;
      SER_DATA:  txd = sh[0];
      SER_PAR:   txd = pbit;
      default:   txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SER_IDLE;
      cnt   <= '0;
      sh    <= '0;
      nbit  <= '0;
      par_q <= 1'b0;
      pbit  <= 1'b0;
    end else begin
      case (st)
        SER_IDLE: begin
          if (!fifo_empty) begin
            st    <= SER_START;
            sh    <= fifo_dout;
            pbit  <= even_par(fifo_dout);
            par_q <= par_en;
            cnt   <= '0;
          end
        end
        SER_START: begin
          if (bit_end) begin
            st   <= SER_DATA;
            cnt  <= '0;
            nbit <= '0;
          end else cnt <= cnt + 32'd1;
        end
        SER_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            sh  <= sh >> 1;
            if (nbit == 3'd7) st <= par_q ? SER_PAR : SER_STOP;
            else nbit <= nbit + 3'd1;
          end else cnt <= cnt + 32'd1;
        end
        SER_PAR: begin
          if (bit_end) begin
            st  <= SER_STOP;
            cnt <= '0;
          end else cnt <= cnt + 32'd1;
        end
        SER_STOP: begin
          if (bit_end) begin
            st  <= SER_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 32'd1;
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_ser.sv
module uart_rx_ser import uart_mmio_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] scale,
  input  logic        par_en,
  input  logic        rxd,
  output logic        done,
  output logic [7:0]  data,
  output logic        par_chk,
  output logic        par_bad,
  output logic        stop_bad
);
  ser_state_e  st;
  logic [31:0] cnt;
  logic [7:0]  sh;
  logic [2:0]  nbit;
  logic        par_q, pbit;
  logic        s1, s2;
  logic        bit_end, mid_end;

  assign bit_end = (cnt == bit_len(scale) - 32'd1);
  assign mid_end = (cnt == mid_len(scale) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SER_IDLE;
      cnt      <= '0;
      sh       <= '0;
      nbit     <= '0;
      par_q    <= 1'b0;
      pbit     <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      par_chk  <= 1'b0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SER_IDLE: begin
          if (!s2) begin
            st  <= SER_START;
            cnt <= '0;
          end
        end
        SER_START: begin
          if (mid_end) begin
            cnt   <= '0;
            nbit  <= '0;
            par_q <= par_en;
            st    <= s2 ? SER_IDLE : SER_DATA;
          end else cnt <= cnt + 32'd1;
        end
        SER_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            sh  <= {s2, sh[7:1]};
            if (nbit == 3'd7) st <= par_q ? SER_PAR : SER_STOP;
            else nbit <= nbit + 3'd1;
          end else cnt <= cnt + 32'd1;
        end
        SER_PAR: begin
          if (bit_end) begin
            cnt  <= '0;
            pbit <= s2;
            st   <= SER_STOP;
          end else cnt <= cnt + 32'd1;
        end
        SER_STOP: begin
          if (bit_end) begin
            cnt      <= '0;
            st       <= SER_IDLE;
            done     <= 1'b1;
            data     <= sh;
            par_chk  <= par_q;
            par_bad  <= par_q && (even_par(sh) != pbit);
            stop_bad <= !s2;
          end else cnt <= cnt + 32'd1;
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio import uart_mmio_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int SCALE_W = 16,
  parameter int THR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic               ctl_par, ctl_txie, ctl_rxie;
  logic [SCALE_W-1:0] scale_q;
  logic [THR_W-1:0]   tx_thr_q, rx_thr_q;
  logic               err_par, err_stop;
  logic [31:0]        scale32;

  // named events for the checker
  logic          tx_push, tx_pop, tx_busy;
  logic          rx_pop, rx_done, rx_drop;
  logic [7:0]    tx_dout, rx_dout, rx_data;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          rx_par_chk, rx_par_bad, rx_stop_bad;
  logic          tx_irq_cond, rx_irq_cond;

  assign scale32 = 32'(scale_q);
  assign tx_push = bus_wr && (bus_addr == OFS_DATA);
  assign rx_pop  = bus_rd && (bus_addr == OFS_DATA);
  assign rx_drop = rx_done && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_par  <= 1'b0;
      ctl_txie <= 1'b0;
      ctl_rxie <= 1'b0;
      scale_q  <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL: begin
          ctl_par  <= bus_wdata[15];
          ctl_txie <= bus_wdata[14];
          ctl_rxie <= bus_wdata[13];
        end
        OFS_SCALE: scale_q  <= bus_wdata[SCALE_W-1:0];
        OFS_TXTHR: tx_thr_q <= bus_wdata[THR_W-1:0];
        OFS_RXTHR: rx_thr_q <= bus_wdata[THR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_par  <= 1'b0;
      err_stop <= 1'b0;
    end else if (rx_done) begin
      if (rx_par_chk) err_par <= rx_par_bad;
      err_stop <= rx_stop_bad;
    end
  end

  uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_done), .din(rx_data),
    .pop(rx_pop), .dout(rx_dout),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  uart_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n),
    .scale(scale32), .par_en(ctl_par),
    .fifo_empty(tx_empty), .fifo_dout(tx_dout),
    .fifo_pop(tx_pop), .busy(tx_busy), .txd(txd)
  );

  uart_rx_ser u_rx (
    .clk(clk), .rst_n(rst_n),
    .scale(scale32), .par_en(ctl_par), .rxd(rxd),
    .done(rx_done), .data(rx_data),
    .par_chk(rx_par_chk), .par_bad(rx_par_bad), .stop_bad(rx_stop_bad)
  );

  assign tx_irq_cond = ctl_txie && level_below(32'(tx_count), 32'(tx_thr_q));
  assign rx_irq_cond = ctl_rxie && level_at_least(32'(rx_count), 32'(rx_thr_q));
  assign irq         = tx_irq_cond || rx_irq_cond;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL:  bus_rdata = pack_status(ctl_par, ctl_txie, ctl_rxie, err_stop, err_par,
                                         rx_empty, rx_full, tx_empty, tx_full);
      OFS_SCALE: bus_rdata = 32'(scale_q);
      OFS_TXTHR: bus_rdata = 32'(tx_thr_q);
      OFS_RXTHR: bus_rdata = 32'(rx_thr_q);
      OFS_DATA:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_dout};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          tx_busy,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          tx_full,
  input logic          tx_empty,
  input logic [CW-1:0] tx_count,
  input logic          rx_pop,
  input logic          rx_done,
  input logic          rx_full,
  input logic          rx_empty,
  input logic [CW-1:0] rx_count,
  input logic [31:0]   bus_rdata
);
  AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty)); // R2

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_count) <= DEPTH); // R2

  AST_TX_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop) |=> $stable(tx_count)); // R2

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R3

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |-> (bus_rdata == 32'd0)); // R5

  AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !rx_done) |=> rx_empty); // R5

  AST_RX_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rx_pop) |=> (rx_full && $stable(rx_count))); // R6
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_empty(tx_empty),
  .tx_count(tx_count), .rx_pop(rx_pop), .rx_done(rx_done), .rx_full(rx_full),
  .rx_empty(rx_empty), .rx_count(rx_count), .bus_rdata(bus_rdata)
);

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h000, A_SCALE = 12'h004,
                          A_TXTHR = 12'h008, A_RXTHR = 12'h00C, A_DATA = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq, rxd_w;
  logic        loop_en = 1'b1;
  logic        drv_rxd = 1'b1;

  int          n_checks = 0;
  int          n_fail = 0;
  int          cur_scale = 8;
  logic        mon_par = 1'b0;
  logic [7:0]  exp_tx[$];
  logic [7:0]  exp_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rxd_w = loop_en ? txd : drv_rxd;

  uart_mmio dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd_w), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: push a byte and record what the line and receiver must show
  task automatic send_byte(input logic [7:0] b, input bit expect_rx);
    exp_tx.push_back(b);
    if (expect_rx) exp_rx.push_back(b);
    wr(A_DATA, {24'hABCDEF, b});
  endtask

  task automatic read_expect(input string req);
    logic [31:0] d;
    logic [7:0]  e;
    rd(A_DATA, d);
    if (exp_rx.size() == 0) check(req, d, 32'd0);
    else begin
      e = exp_rx.pop_front();
      check(req, d, {24'd0, e});
    end
  endtask

  task automatic drain();
    while (exp_tx.size() != 0) @(negedge clk);
    repeat (3 * cur_scale + 6) @(negedge clk);
  endtask

  // hand-built receive frame
  task automatic rx_frame(input logic [7:0] b, input bit bad_par, input logic stop_v);
    @(negedge clk);
    drv_rxd = 1'b0;
    repeat (cur_scale) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drv_rxd = b[i];
      repeat (cur_scale) @(negedge clk);
    end
    if (mon_par) begin
      drv_rxd = (^b) ^ bad_par;
      repeat (cur_scale) @(negedge clk);
    end
    drv_rxd = stop_v;
    repeat (cur_scale) @(negedge clk);
    drv_rxd = 1'b1;
    repeat (3 * cur_scale) @(negedge clk);
  endtask

  // monitor: decode every frame on txd and compare with the scoreboard (R3)
  initial begin
    forever begin
      int         sc;
      logic [7:0] got;
      logic       pb, st0, sp, usep;
      logic [7:0] e;
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        sc = cur_scale;
        usep = mon_par;
        repeat (sc / 2) @(negedge clk);
        st0 = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (sc) @(negedge clk);
          got[i] = txd;
        end
        pb = 1'b0;
        if (usep) begin
          repeat (sc) @(negedge clk);
          pb = txd;
        end
        repeat (sc) @(negedge clk);
        sp = txd;
        check("R3 start bit", {31'd0, st0}, 32'd0);
        check("R3 stop bit", {31'd0, sp}, 32'd1);
        if (exp_tx.size() == 0) check("R3 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
        else begin
          e = exp_tx.pop_front();
          check("R3 data bits", {24'd0, got}, {24'd0, e});
          if (usep) check("R3 parity bit", {31'd0, pb}, {31'd0, ^e});
        end
      end
    end
  end

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d);       check("R1 status", d, 32'h22);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 txd", {31'd0, txd}, 32'd1);
    // R5 empty read
    rd(A_DATA, d);       check("R5 empty read", d, 32'd0);
    rd(A_CTRL, d);       check("R5 still empty", d, 32'h22);

    // R11 readback
    wr(A_TXTHR, 32'hFF); rd(A_TXTHR, d); check("R11 tx thr", d, 32'h1F);
    wr(A_RXTHR, 32'h13); rd(A_RXTHR, d); check("R11 rx thr", d, 32'h13);
    wr(A_SCALE, 32'h0001_1234); rd(A_SCALE, d); check("R11 scaler", d, 32'h1234);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R11 ctrl", d, 32'h0000_E022);
    wr(A_CTRL, 32'h0);   check("R10 irq off", {31'd0, irq}, 32'd0);

    // R3/R4 loopback, no parity
    cur_scale = 8; wr(A_SCALE, 8);
    send_byte(8'hA5, 1); send_byte(8'h3C, 1); send_byte(8'h00, 1); send_byte(8'hFF, 1);
    drain();
    repeat (4) read_expect("R4 rx byte");
    rd(A_CTRL, d); check("R4 rx empty again", d, 32'h22);

    // R3/R7 loopback with parity
    mon_par = 1'b1; wr(A_CTRL, 32'h8000);
    send_byte(8'h5A, 1); send_byte(8'h81, 1); send_byte(8'h7F, 1);
    drain();
    rd(A_CTRL, d); check("R7 good parity no error", d & 32'h300, 32'h0);
    repeat (3) read_expect("R4 rx byte parity");

    // R2/R6/R9/R10 fill both FIFOs
    mon_par = 1'b0; wr(A_CTRL, 32'h0);
    cur_scale = 40; wr(A_SCALE, 40);
    send_byte(8'h40, 1);
    repeat (5) @(negedge clk);
    for (int k = 1; k < 20; k++) begin
      if (k <= 16) send_byte(8'(8'h40 + k), k <= 15);
      else wr(A_DATA, 32'(8'h40 + k));
    end
    rd(A_CTRL, d); check("R2 tx full flag", d & 32'h3, 32'h1);
    wr(A_TXTHR, 5);  wr(A_CTRL, 32'h4000);
    check("R9 irq count 16 thr 5", {31'd0, irq}, 32'd0);
    wr(A_TXTHR, 17);
    check("R9 irq count 16 thr 17", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 32'h0);
    drain();
    rd(A_CTRL, d); check("R6 rx full flag", d & 32'h33, 32'h12);
    wr(A_RXTHR, 16); wr(A_CTRL, 32'h2000);
    check("R10 irq count 16 thr 16", {31'd0, irq}, 32'd1);
    wr(A_RXTHR, 17);
    check("R10 irq count 16 thr 17", {31'd0, irq}, 32'd0);
    wr(A_RXTHR, 16);
    read_expect("R6 oldest kept");
    check("R10 irq count 15 thr 16", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h4000); wr(A_TXTHR, 1);
    check("R9 irq empty thr 1", {31'd0, irq}, 32'd1);
    wr(A_TXTHR, 0);
    check("R9 irq empty thr 0", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h0);
    repeat (15) read_expect("R6 kept byte");
    rd(A_DATA, d); check("R6 overrun byte discarded", d, 32'd0);

    // R7/R8 hand-built frames
    loop_en = 1'b0; cur_scale = 8; wr(A_SCALE, 8);
    mon_par = 1'b1; wr(A_CTRL, 32'h8000);
    exp_rx.push_back(8'h33); rx_frame(8'h33, 1, 1'b1);
    rd(A_CTRL, d); check("R7 parity error set", d & 32'h300, 32'h100);
    exp_rx.push_back(8'h34); rx_frame(8'h34, 0, 1'b1);
    rd(A_CTRL, d); check("R7 parity error cleared", d & 32'h300, 32'h0);
    exp_rx.push_back(8'h55); rx_frame(8'h55, 0, 1'b0);
    rd(A_CTRL, d); check("R8 stop error set", d & 32'h300, 32'h200);
    exp_rx.push_back(8'h66); rx_frame(8'h66, 0, 1'b1);
    rd(A_CTRL, d); check("R8 stop error cleared", d & 32'h300, 32'h0);
    repeat (4) read_expect("R7 stored bytes");
    rd(A_DATA, d); check("R5 empty after errors", d, 32'd0);

    finish_sim();
  end
endmodule